// File: doc/BRIEF.md
# Interrupt Message Write Status Register

This block is a 64-bit memory-mapped status register that follows the message writes sent on behalf of three interrupt sources: fault handling, error recovery and critical error. Each source has two bits. A read-only in-progress bit is set while a message write started by that source's interrupt has not yet completed. A sticky error bit records that such a write completed with an error response.

A write engine outside the block reports each source's activity with a start pulse and a completion pulse. The completion pulse comes with an error flag. Software reads the register over a simple register bus at one fixed byte offset. It clears error bits by writing ones to them. The in-progress bit only reports an outstanding write. It does not say whether the interrupt itself is active.

A parameter mask marks which of the three sources exist. The bits of a missing source always read as zero. The same six bits are also driven out continuously as a status vector.

Top module: `irq_msg_wr_status`

## Requirements
- R1: Register bits 63 to 6 always read as zero, and bus writes to them have no effect.
- R2: Source index 0 is fault handling, 1 is error recovery and 2 is critical error. Source i places its in-progress bit at bit 2*i and its error bit at bit 2*i+1, both in the read data and in `status_o`.
- R3: When a source is idle, a start pulse sets its in-progress bit in the following cycle. A completion pulse while it is busy clears the bit in the following cycle. A start pulse while busy has no effect, and so does a completion pulse while idle.
- R4: A completion pulse with its error flag high, arriving while the source is busy, sets the error bit in the following cycle. The bit then stays at 1 through any later completions, with or without error.
- R5: A bus write at the register offset clears, in the following cycle, each error bit whose write-data bit is 1. An error bit whose write-data bit is 0 is left unchanged.
- R6: When an error completion and a write-one-to-clear reach the same error bit in the same cycle, the bit is 1 afterwards.
- R7: Bus writes never change an in-progress bit.
- R8: A read is accepted when `bus_req_i` is high and `bus_we_i` is low. In the next cycle `bus_rvalid_o` is 1. `bus_rdata_o` then holds the register value as it was when the read was accepted if the address equals `REG_OFFSET` (default 0xEF8), and 0 for any other address. Accesses to other addresses change nothing.
- R9: When bit i of `SRC_PRESENT` is 0, bits 2*i and 2*i+1 read as zero and stay zero whatever arrives on that source's inputs.
- R10: After a synchronous active-low reset, every status bit, the read data and the read-valid flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | ADDR_W (12) | Byte offset within the register frame |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data returned, one cycle after the read |
| wr_start_i | input | 3 | Per-source pulse: interrupt message write started |
| wr_done_i | input | 3 | Per-source pulse: interrupt message write completed |
| wr_err_i | input | 3 | Per-source error flag, qualified by wr_done_i |
| status_o | output | 6 | Live status bits, same layout as register bits 5 to 0 |

## Verification
A wrong in-progress state shows on `status_o` one cycle after the start or completion pulse that exposes it. It also shows in the read data one cycle after the next read. A lost or spurious error bit stays wrong until it is cleared, because the bit is sticky. The bench therefore compares the full status vector after every cycle, and the read data after every read, against an arithmetic model. A second instance, with one source present, is compared against the same model with the missing sources masked to zero.

// File: rtl/irq_msg_wr_pkg.sv
// Package: shared constants, types and helpers for the interrupt message
// write status register. Assumes two status bits per source.
package irq_msg_wr_pkg;

    localparam int unsigned REG_W       = 64;
    localparam int unsigned NUM_SRC     = 3;
    localparam int unsigned BITS_PER_SRC = 2;
    localparam int unsigned STAT_W      = NUM_SRC * BITS_PER_SRC;

    // Source order fixes the bit positions seen by software.
    typedef enum logic [1:0] {
        SRC_FAULT    = 2'd0,
        SRC_RECOVERY = 2'd1,
        SRC_CRITICAL = 2'd2
    } src_id_e;

    // Two bits per source, error above in-progress.
    typedef struct packed {
        logic err;
        logic busy;
    } src_stat_t;

    // Bit index of a source's in-progress flag.
    function automatic int unsigned busy_pos(input int unsigned src);
        return src * BITS_PER_SRC;
    endfunction

    // Bit index of a source's error flag.
    function automatic int unsigned err_pos(input int unsigned src);
        return src * BITS_PER_SRC + 1;
    endfunction

endpackage

// File: rtl/imw_src_tracker.sv
// Module: per-source tracker. Holds the in-progress flag of one interrupt
// message write and the sticky error flag of its completions.
// Assumes at most one outstanding write per source. Start is ignored while
// busy and completion is ignored while idle. An error set wins over a clear
// in the same cycle.
module imw_src_tracker
    import irq_msg_wr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      done_i,
    input  logic      done_err_i,
    input  logic      clr_i,
    output src_stat_t stat_o
);

    logic busy_q;
    logic err_q;
    logic err_set;

    // Error completion qualified by an outstanding write.
    assign err_set = busy_q & done_i & done_err_i;

    // Track the outstanding write: set on start while idle, clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (done_i) begin
                busy_q <= 1'b0;
            end
        end else if (start_i) begin
            busy_q <= 1'b1;
        end
    end

    // Sticky error flag: a set beats a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (clr_i) begin
            err_q <= 1'b0;
        end
    end

    // Present the pair to the register assembly.
    always_comb begin
        stat_o.busy = busy_q;
        stat_o.err  = err_q;
    end

endmodule

// File: rtl/imw_bus_port.sv
// Module: register bus port. Decodes the single register offset, turns
// writes into per-source clear strobes and returns read data one cycle
// after a read. Assumes single-cycle request pulses with no back-pressure.
module imw_bus_port
    import irq_msg_wr_pkg::*;
#(
    parameter int unsigned         ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]   REG_OFFSET = 12'hEF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              rvalid_o
);

    localparam int unsigned PAD_W = REG_W - STAT_W;

    logic addr_hit;
    logic rd_acc;
    logic wr_hit;
    logic unused_wdata;

    // Decode the one implemented offset.
    assign addr_hit = (addr_i == REG_OFFSET);
    assign rd_acc   = req_i & ~we_i;
    assign wr_hit   = req_i &  we_i & addr_hit;

    // Pick the error-bit lanes of the write data as clear strobes.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
        assign clr_o[s] = wr_hit & wdata_i[err_pos(s)];
    end

    // Write lanes that map to nothing, kept only for completeness.
    assign unused_wdata = ^{wdata_i[REG_W-1:STAT_W], wdata_i[4], wdata_i[2], wdata_i[0]};

    // Register read data; misses and non-reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            rvalid_o <= rd_acc;
            rdata_o  <= (rd_acc && addr_hit) ? {{PAD_W{1'b0}}, stat_i} : '0;
        end
    end

endmodule

// File: rtl/irq_msg_wr_status.sv
// Module: top of the interrupt message write status register. Instantiates
// one tracker per present source, ties absent sources to zero and attaches
// the bus port. Assumes SRC_PRESENT bit i enables source i
// (0 fault, 1 recovery, 2 critical).
module irq_msg_wr_status
    import irq_msg_wr_pkg::*;
#(
    parameter int unsigned         ADDR_W      = 12,
    parameter logic [ADDR_W-1:0]   REG_OFFSET  = 12'hEF8,
    parameter logic [NUM_SRC-1:0]  SRC_PRESENT = 3'b111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [REG_W-1:0]   bus_wdata_i,
    output logic [REG_W-1:0]   bus_rdata_o,
    output logic               bus_rvalid_o,
    input  logic [NUM_SRC-1:0] wr_start_i,
    input  logic [NUM_SRC-1:0] wr_done_i,
    input  logic [NUM_SRC-1:0] wr_err_i,
    output logic [STAT_W-1:0]  status_o
);

    logic [NUM_SRC-1:0] clr;
    src_stat_t          stat [NUM_SRC];

    // One tracker per present source, constant zero otherwise.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (SRC_PRESENT[s]) begin : g_on
            imw_src_tracker u_trk (
                .clk        (clk),
                .rst_n      (rst_n),
                .start_i    (wr_start_i[s]),
                .done_i     (wr_done_i[s]),
                .done_err_i (wr_err_i[s]),
                .clr_i      (clr[s]),
                .stat_o     (stat[s])
            );
        end else begin : g_off
            logic unused_in;
            assign unused_in = ^{wr_start_i[s], wr_done_i[s], wr_err_i[s], clr[s]};
            assign stat[s]   = '0;
        end
        // Place the pair at its fixed bit positions.
        assign status_o[busy_pos(s)] = stat[s].busy;
        assign status_o[err_pos(s)]  = stat[s].err;
    end

    imw_bus_port #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (bus_req_i),
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .stat_i   (status_o),
        .clr_o    (clr),
        .rdata_o  (bus_rdata_o),
        .rvalid_o (bus_rvalid_o)
    );

endmodule

// File: rtl/irq_msg_wr_status_chk.sv
// Module: assertion checker bound to the top. It observes ports only and
// checks the status bit rules cycle by cycle.
module irq_msg_wr_status_chk
    import irq_msg_wr_pkg::*;
#(
    parameter int unsigned         ADDR_W      = 12,
    parameter logic [ADDR_W-1:0]   REG_OFFSET  = 12'hEF8,
    parameter logic [NUM_SRC-1:0]  SRC_PRESENT = 3'b111
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req_i,
    input logic               bus_we_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [REG_W-1:0]   bus_wdata_i,
    input logic [REG_W-1:0]   bus_rdata_o,
    input logic               bus_rvalid_o,
    input logic [NUM_SRC-1:0] wr_start_i,
    input logic [NUM_SRC-1:0] wr_done_i,
    input logic [NUM_SRC-1:0] wr_err_i,
    input logic [STAT_W-1:0]  status_o
);

    logic wr_hit;
    assign wr_hit = bus_req_i & bus_we_i & (bus_addr_i == REG_OFFSET);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> (bus_rdata_o[REG_W-1:STAT_W] == '0)); // R1

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && !bus_we_i && bus_addr_i != REG_OFFSET) |=> (bus_rdata_o == '0)); // R8

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_addr_i != REG_OFFSET && wr_start_i == '0 && wr_done_i == '0)
        |=> $stable(status_o)); // R8

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        if (SRC_PRESENT[s]) begin : g_on
            AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (!status_o[busy_pos(s)] && wr_start_i[s]) |=> status_o[busy_pos(s)]); // R3
            AST_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (status_o[busy_pos(s)] && wr_done_i[s]) |=> !status_o[busy_pos(s)]); // R3
            AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (status_o[busy_pos(s)] && wr_done_i[s] && wr_err_i[s]) |=> status_o[err_pos(s)]); // R6
            AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (status_o[err_pos(s)] && !(wr_hit && bus_wdata_i[err_pos(s)]))
                |=> status_o[err_pos(s)]); // R4
            AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && bus_wdata_i[err_pos(s)] &&
                 !(status_o[busy_pos(s)] && wr_done_i[s] && wr_err_i[s]))
                |=> !status_o[err_pos(s)]); // R5
            AST_BUSY_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_start_i[s] && !wr_done_i[s]) |=> $stable(status_o[busy_pos(s)])); // R7
        end else begin : g_off
            AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                status_o[err_pos(s):busy_pos(s)] == 2'b00); // R9
        end
    end

endmodule

bind irq_msg_wr_status irq_msg_wr_status_chk #(
    .ADDR_W      (ADDR_W),
    .REG_OFFSET  (REG_OFFSET),
    .SRC_PRESENT (SRC_PRESENT)
) u_chk (.*);

// File: tb/irq_msg_wr_status_bench.sv
// Bench: drives both a full instance and one with only the recovery source,
// and compares every cycle against an arithmetic model of the bit rules.
module irq_msg_wr_status_bench;

    localparam logic [11:0] OFF       = 12'hEF8;
    localparam logic [2:0]  PART_MASK = 3'b010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [2:0]  st = '0, dn = '0, de = '0;

    logic [63:0] rdata_f, rdata_p;
    logic        rvalid_f, rvalid_p;
    logic [5:0]  stat_f, stat_p;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [2:0] m_busy = '0;
    logic [2:0] m_err  = '0;

    always #10 clk = ~clk;

    irq_msg_wr_status u_irq_msg_wr_status (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_f),
        .bus_rvalid_o(rvalid_f), .wr_start_i(st), .wr_done_i(dn),
        .wr_err_i(de), .status_o(stat_f)
    );

    irq_msg_wr_status #(.SRC_PRESENT(PART_MASK)) u_irq_msg_wr_status_part (
        .clk(clk), .rst_n(rst_n), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_p),
        .bus_rvalid_o(rvalid_p), .wr_start_i(st), .wr_done_i(dn),
        .wr_err_i(de), .status_o(stat_p)
    );

    function automatic logic [5:0] pack(input logic [2:0] b, input logic [2:0] e,
                                        input logic [2:0] mask);
        logic [5:0] v;
        for (int s = 0; s < 3; s++) begin
            v[2*s]   = b[s] & mask[s];
            v[2*s+1] = e[s] & mask[s];
        end
        return v;
    endfunction

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus/engine cycle: drive at negedge, update model, compare at next negedge.
    task automatic cyc(input logic [2:0] i_st, input logic [2:0] i_dn, input logic [2:0] i_de,
                       input logic i_rq, input logic i_we, input logic [11:0] i_ad,
                       input logic [63:0] i_wd, input string tag);
        logic [2:0]  clr, eset, nb, ne;
        logic [63:0] er_f, er_p;
        logic        ev;
        st = i_st; dn = i_dn; de = i_de; req = i_rq; we = i_we; addr = i_ad; wdata = i_wd;
        clr  = (i_rq && i_we && i_ad == OFF) ? {i_wd[5], i_wd[3], i_wd[1]} : 3'b000;
        eset = m_busy & i_dn & i_de;
        nb   = (m_busy & ~i_dn) | (~m_busy & i_st);
        ne   = eset | (m_err & ~clr);
        ev   = i_rq & ~i_we;
        er_f = (ev && i_ad == OFF) ? {58'd0, pack(m_busy, m_err, 3'b111)} : 64'd0;
        er_p = (ev && i_ad == OFF) ? {58'd0, pack(m_busy, m_err, PART_MASK)} : 64'd0;
        @(posedge clk);
        m_busy = nb; m_err = ne;
        @(negedge clk);
        st = '0; dn = '0; de = '0; req = 1'b0; we = 1'b0;
        chk64({tag, " status"},      {58'd0, stat_f}, {58'd0, pack(m_busy, m_err, 3'b111)});
        chk64({tag, " R9 status"},   {58'd0, stat_p}, {58'd0, pack(m_busy, m_err, PART_MASK)});
        chk64({tag, " R8 rvalid"},   {63'd0, rvalid_f}, {63'd0, ev});
        chk64({tag, " R8 rdata"},    rdata_f, er_f);
        chk64({tag, " R9 rdata"},    rdata_p, er_p);
    endtask

    task automatic rd(input string tag);
        cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b0, OFF, 64'd0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state
        chk64("R10 status", {58'd0, stat_f}, 64'd0);
        chk64("R10 rdata",  rdata_f, 64'd0);
        chk64("R10 rvalid", {63'd0, rvalid_f}, 64'd0);
        rst_n = 1'b1;
        rd("R10 R1 first read");

        // R2 R3 R4: each source, repeated starts/completions, sticky errors
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 4; k++) begin
                logic [2:0] one;
                one = 3'b001 << s;
                cyc(one, 3'b0, 3'b0, 1'b0, 1'b0, OFF, 64'd0, "R3 start");
                cyc(one, 3'b0, 3'b0, 1'b0, 1'b0, OFF, 64'd0, "R3 start while busy");
                rd("R2 busy position");
                cyc(3'b0, one, (k[0] ? one : 3'b0), 1'b0, 1'b0, OFF, 64'd0, "R4 completion");
                cyc(3'b0, one, one, 1'b0, 1'b0, OFF, 64'd0, "R3 completion while idle");
                rd("R2 R4 sticky read");
            end
        end

        // R7 R5 R1: writes of all ones while every source is busy
        cyc(3'b111, 3'b0, 3'b0, 1'b0, 1'b0, OFF, 64'd0, "R3 all start");
        for (int p = 0; p < 8; p++) begin
            cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b1, OFF,
                {58'h3FF_FFFF_FFFF_FFFF, p[2], 1'b1, p[1], 1'b1, p[0], 1'b1}, "R5 R7 R1 write");
            rd("R5 R7 read back");
            cyc(3'b111, 3'b111, 3'b111, 1'b0, 1'b0, OFF, 64'd0, "R4 re-error");
            cyc(3'b111, 3'b0, 3'b0, 1'b0, 1'b0, OFF, 64'd0, "R3 restart");
        end

        // R5: clear while nothing arrives, then write zero leaves errors
        cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b1, OFF, 64'd0, "R5 write zero keeps");
        cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b1, OFF, 64'h2A, "R5 clear all");
        rd("R5 cleared stays zero");

        // R6: error completion and clear in the same cycle
        cyc(3'b0, 3'b111, 3'b101, 1'b1, 1'b1, OFF, 64'h2A, "R6 set wins");
        rd("R6 read");

        // R8: other offsets, reads and writes
        for (int a = 0; a < 6; a++) begin
            logic [11:0] ad;
            ad = OFF ^ (12'h001 << (a * 2));
            cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b1, ad, 64'hFFFF_FFFF_FFFF_FFFF, "R8 miss write");
            cyc(3'b0, 3'b0, 3'b0, 1'b1, 1'b0, ad, 64'd0, "R8 miss read");
        end
        rd("R8 after misses");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule